// File: doc/BRIEF.md
# I/O-Mapped Bus Slave Agent

This block is a slave on a shared bus that carries an address, a set of control lines and data. It watches every transfer and answers only one: a single address in one address space, read or written. A write to that location stores the bus data in an internal register. A read from it places the stored value on the bus through a drive-enable that feeds the bus's tri-state buffer. The agent then pulses an acknowledge so the master can end the transfer. It also holds an interrupt request line that software sets by writing and clears by reading.

The select comes from two cascaded decode stages. One compares the address bus with the device address. The other checks the control lines, which give the space (I/O or memory) and the read and write strobes. The first stage enables the second. A parameter chooses which of the two stages comes first. The final select is the same in either order. The default device answers I/O-space accesses at address 0x0F.

Top module: `bus_slave_agent`

## Requirements
- R1: A transfer selects the device only when `bus_addr` equals `DEV_ADDR` (default 0x0F) and `bus_io` is 1, which marks I/O space. A transfer at any other address, or with `bus_io` at 0 (memory space), changes no output and does not alter the stored value or the interrupt.
- R2: A matched write has `bus_wr`=1 and `bus_rd`=0. On every rising clock edge where a matched write is present, the stored register takes the value of `bus_din`. If the write is held for several cycles, the register keeps the last value.
- R3: A matched read has `bus_rd`=1 and `bus_wr`=0. In the cycle after each clock edge where a matched read is present, `drv_en` is 1 and `drv_data` shows the stored value. At all other times `drv_en` is 0 and `drv_data` is 0.
- R4: `ack` is a one-cycle pulse in the cycle after the first edge of a matched access. It stays low while the select remains true. It pulses again only after the select has dropped for at least one edge and then returns.
- R5: A matched write of a nonzero value sets `irq` from the next cycle. A matched write of zero leaves `irq` unchanged.
- R6: A matched read clears `irq` from the next cycle.
- R7: A transfer with both `bus_rd` and `bus_wr` at 1 selects nothing. It drives nothing, gives no `ack`, stores nothing and leaves `irq` unchanged.
- R8: While `rst_n` is 0, `drv_en`, `drv_data`, `ack` and `irq` are 0, and the stored value returns to 0.
- R9: The two decode orders (`DECODE_ORDER` address-first or control-first) give identical behaviour at the ports for every input sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Address bus |
| bus_io | input | 1 | Space select: 1 = I/O, 0 = memory |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_din | input | DATA_W | Data bus as seen by the agent |
| drv_data | output | DATA_W | Value to place on the data bus |
| drv_en | output | 1 | Tri-state enable for `drv_data` |
| ack | output | 1 | Transfer-complete pulse |
| irq | output | 1 | Interrupt request level |

## Verification
The bench targets partial matches. These include the right address in memory space, the wrong address in I/O space, and both strobes high together. A decoder that is not fully qualified would store data, drive the bus or raise `ack` on one of these. A held write with changing data checks that the last value is kept, and that `ack` fires only once. A design that pulses on every select cycle would repeat `ack`. A design that latches on the first edge only would store the wrong value. A zero write after a nonzero one must leave `irq` high, and a reset in the middle of a run must clear the pending interrupt. The bench builds one instance for each decode order and compares both against the same model, so a defect in only one cascade order shows up.

// File: rtl/slave_agent_pkg.sv
package slave_agent_pkg;

    typedef enum logic {
        DEC_ADDR_FIRST = 1'b0,
        DEC_CTRL_FIRST = 1'b1
    } dec_order_e;

    typedef struct packed {
        logic io;
        logic rd;
        logic wr;
    } bus_ctrl_t;

    // A single strobe must be active; both or neither means no function.
    function automatic logic is_write(bus_ctrl_t c, logic space);
        return (c.io == space) && c.wr && !c.rd;
    endfunction

    function automatic logic is_read(bus_ctrl_t c, logic space);
        return (c.io == space) && c.rd && !c.wr;
    endfunction

endpackage

// File: rtl/slave_addr_stage.sv
module slave_addr_stage #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h0F
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    always_comb begin
        hit = en && (addr == DEV_ADDR);
    end
endmodule

// File: rtl/slave_ctrl_stage.sv
module slave_ctrl_stage
    import slave_agent_pkg::*;
#(
    parameter logic SPACE = 1'b1
) (
    input  logic      en,
    input  bus_ctrl_t ctrl,
    output logic      wr_hit,
    output logic      rd_hit
);
    always_comb begin
        wr_hit = en && is_write(ctrl, SPACE);
        rd_hit = en && is_read(ctrl, SPACE);
    end
endmodule

// File: rtl/slave_decoder.sv
module slave_decoder
    import slave_agent_pkg::*;
#(
    parameter int                ADDR_W = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h0F,
    parameter logic              SPACE = 1'b1,
    parameter dec_order_e        ORDER = DEC_ADDR_FIRST
) (
    input  logic [ADDR_W-1:0] addr,
    input  bus_ctrl_t         ctrl,
    output logic              sel_wr,
    output logic              sel_rd
);
    generate
        if (ORDER == DEC_ADDR_FIRST) begin : g_addr_first
            logic a_hit;
            slave_addr_stage #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_addr (
                .en   (1'b1),
                .addr (addr),
                .hit  (a_hit)
            );
            slave_ctrl_stage #(.SPACE(SPACE)) u_ctrl (
                .en     (a_hit),
                .ctrl   (ctrl),
                .wr_hit (sel_wr),
                .rd_hit (sel_rd)
            );
        end else begin : g_ctrl_first
            logic c_wr, c_rd, a_hit;
            slave_ctrl_stage #(.SPACE(SPACE)) u_ctrl (
                .en     (1'b1),
                .ctrl   (ctrl),
                .wr_hit (c_wr),
                .rd_hit (c_rd)
            );
            slave_addr_stage #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_addr (
                .en   (c_wr | c_rd),
                .addr (addr),
                .hit  (a_hit)
            );
            assign sel_wr = c_wr & a_hit;
            assign sel_rd = c_rd & a_hit;
        end
    endgenerate
endmodule

// File: rtl/bus_slave_agent.sv
module bus_slave_agent
    import slave_agent_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter int                DATA_W       = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR     = 8'h0F,
    parameter logic              SPACE        = 1'b1,
    parameter dec_order_e        DECODE_ORDER = DEC_ADDR_FIRST
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_io,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] drv_data,
    output logic              drv_en,
    output logic              ack,
    output logic              irq
);
    localparam logic [DATA_W-1:0] ZERO = '0;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              irq;
        logic              ack;
        logic              served;
        logic              drv;
    } agent_state_t;

    localparam agent_state_t RESET_STATE = '{data: ZERO, irq: 1'b0, ack: 1'b0,
                                             served: 1'b0, drv: 1'b0};

    bus_ctrl_t    ctrl;
    logic         sel_wr, sel_rd, sel_any;
    agent_state_t st_d, st_q;

    assign ctrl = '{io: bus_io, rd: bus_rd, wr: bus_wr};

    slave_decoder #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR),
        .SPACE    (SPACE),
        .ORDER    (DECODE_ORDER)
    ) u_dec (
        .addr   (bus_addr),
        .ctrl   (ctrl),
        .sel_wr (sel_wr),
        .sel_rd (sel_rd)
    );

    assign sel_any = sel_wr | sel_rd;

    always_comb begin
        st_d        = st_q;
        st_d.ack    = sel_any && !st_q.served;
        st_d.served = sel_any;
        st_d.drv    = sel_rd;
        if (sel_wr) begin
            st_d.data = bus_din;
            if (bus_din != ZERO) begin
                st_d.irq = 1'b1;
            end
        end
        if (sel_rd) begin
            st_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign drv_en   = st_q.drv;
    assign drv_data = st_q.drv ? st_q.data : ZERO;
    assign ack      = st_q.ack;
    assign irq      = st_q.irq;

endmodule

// File: rtl/bus_slave_agent_checker.sv
module bus_slave_agent_checker #(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] DEV_ADDR = 8'h0F,
    parameter logic              SPACE    = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_io,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_din,
    input logic [DATA_W-1:0] drv_data,
    input logic              drv_en,
    input logic              ack,
    input logic              irq
);
    logic at_dev, rd_match, wr_match, any_match;
    assign at_dev    = (bus_addr == DEV_ADDR) && (bus_io == SPACE);
    assign rd_match  = at_dev && bus_rd && !bus_wr;
    assign wr_match  = at_dev && bus_wr && !bus_rd;
    assign any_match = rd_match | wr_match;

    // R3: the bus is driven only after a matched read edge
    assert_drive_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> $past(rd_match));

    // R3: an idle drive value is zero
    assert_idle_data_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> (drv_data == '0));

    // R4: ack never lasts two cycles
    assert_ack_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R4: ack only after a matched access
    assert_ack_needs_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(any_match));

    // R5: interrupt rises only on a nonzero matched write
    assert_irq_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(wr_match && (bus_din != '0)));

    // R6: interrupt falls only on a matched read
    assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(rd_match));

    // R7: both strobes together select nothing
    assert_dual_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> (!drv_en && !ack && $stable(irq)));

    // R8: outputs quiet during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R8: assert (!drv_en && !ack && !irq && drv_data == '0);
        end
    end
endmodule

bind bus_slave_agent bus_slave_agent_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEV_ADDR (DEV_ADDR),
    .SPACE    (SPACE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_io   (bus_io),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .bus_din  (bus_din),
    .drv_data (drv_data),
    .drv_en   (drv_en),
    .ack      (ack),
    .irq      (irq)
);

// File: tb/bus_slave_agent_bench.sv
module bus_slave_agent_bench;
    import slave_agent_pkg::*;

    localparam logic [7:0] DEV = 8'h0F;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr;
    logic       bus_io, bus_rd, bus_wr;
    logic [7:0] bus_din;

    logic [7:0] a_data, b_data;
    logic       a_en, b_en, a_ack, b_ack, a_irq, b_irq;

    always #4 clk = ~clk;   // 125 MHz

    bus_slave_agent #(.DECODE_ORDER(DEC_ADDR_FIRST)) u_bus_slave_agent (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_din(bus_din),
        .drv_data(a_data), .drv_en(a_en), .ack(a_ack), .irq(a_irq));

    bus_slave_agent #(.DECODE_ORDER(DEC_CTRL_FIRST)) u_bus_slave_agent_alt (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_din(bus_din),
        .drv_data(b_data), .drv_en(b_en), .ack(b_ack), .irq(b_irq));

    int    compared = 0;
    int    mismatched = 0;
    bit    done = 1'b0;
    string last_tag = "R8 power-up";

    // behavioural reference state
    int m_data = 0;
    bit m_irq = 0, m_ack = 0, m_served = 0, m_drv = 0;

    task automatic check_one(string tag, logic en, logic [7:0] d, logic a, logic i);
        logic [7:0] exp_d;
        exp_d = m_drv ? m_data[7:0] : 8'h00;
        compared++;
        if ({en, d, a, i} !== {m_drv, exp_d, m_ack, m_irq}) begin
            mismatched++;
            $display("FAIL %s: actual en=%0b data=%02h ack=%0b irq=%0b expected en=%0b data=%02h ack=%0b irq=%0b",
                     tag, en, d, a, i, m_drv, exp_d, m_ack, m_irq);
        end
    endtask

    task automatic cycle(string tag, bit rst, logic [7:0] a, bit io, bit rd, bit wr, logic [7:0] din);
        bit sw, sr;
        @(negedge clk);
        check_one(last_tag, a_en, a_data, a_ack, a_irq);
        check_one({last_tag, " order=ctrl-first R9"}, b_en, b_data, b_ack, b_irq);
        rst_n = rst; bus_addr = a; bus_io = io; bus_rd = rd; bus_wr = wr; bus_din = din;
        last_tag = tag;
        @(posedge clk);
        if (!rst) begin
            m_data = 0; m_irq = 0; m_ack = 0; m_served = 0; m_drv = 0;
        end else begin
            sw = io && wr && !rd && (a == DEV);
            sr = io && rd && !wr && (a == DEV);
            m_ack    = (sw || sr) && !m_served;
            m_served = sw || sr;
            m_drv    = sr;
            if (sw) begin
                m_data = din;
                if (din != 0) m_irq = 1;
            end
            if (sr) m_irq = 0;
        end
    endtask

    task automatic idle(string tag);
        cycle(tag, 1, 8'h00, 0, 0, 0, 8'h00);
    endtask

    initial begin
        rst_n = 1'b0; bus_addr = '0; bus_io = 0; bus_rd = 0; bus_wr = 0; bus_din = '0;
        repeat (3) cycle("R8 held in reset", 0, DEV, 1, 1, 0, 8'h00);
        idle("R3 idle after reset");
        // single write then held read
        cycle("R2 R5 write 5A", 1, DEV, 1, 0, 1, 8'h5A);
        idle("R4 ack after write");
        cycle("R3 R6 read", 1, DEV, 1, 1, 0, 8'h00);
        cycle("R4 R3 read held", 1, DEV, 1, 1, 0, 8'h00);
        idle("R3 drive off");
        // held write with changing data
        cycle("R2 held write 1", 1, DEV, 1, 0, 1, 8'h11);
        cycle("R4 R2 held write 2", 1, DEV, 1, 0, 1, 8'h22);
        cycle("R4 R2 held write 3", 1, DEV, 1, 0, 1, 8'hC3);
        idle("R4 after held write");
        // partial matches
        cycle("R1 memory space write", 1, DEV, 0, 0, 1, 8'h33);
        cycle("R1 wrong address write", 1, 8'h0E, 1, 0, 1, 8'h44);
        cycle("R1 wrong address read", 1, 8'h1F, 1, 1, 0, 8'h00);
        cycle("R1 memory space read", 1, DEV, 0, 1, 0, 8'h00);
        cycle("R1 read back C3", 1, DEV, 1, 1, 0, 8'h00);
        idle("R1 after read");
        cycle("R7 both strobes", 1, DEV, 1, 1, 1, 8'h77);
        idle("R7 after both strobes");
        cycle("R7 read back", 1, DEV, 1, 1, 0, 8'h00);
        idle("R7 idle");
        // zero write keeps irq
        cycle("R5 nonzero write", 1, DEV, 1, 0, 1, 8'h09);
        idle("R5 irq set");
        cycle("R5 zero write", 1, DEV, 1, 0, 1, 8'h00);
        idle("R5 irq kept after zero");
        idle("R5 irq still set");
        cycle("R6 clearing read", 1, DEV, 1, 1, 0, 8'h00);
        idle("R6 irq cleared");
        // select drops and returns: ack again
        cycle("R4 write A", 1, DEV, 1, 0, 1, 8'hA1);
        idle("R4 gap");
        cycle("R4 write B", 1, DEV, 1, 0, 1, 8'hB2);
        cycle("R4 write to read switch", 1, DEV, 1, 1, 0, 8'h00);
        idle("R4 after switch");
        // mid-run reset with pending irq
        cycle("R5 set before reset", 1, DEV, 1, 0, 1, 8'h5F);
        cycle("R8 mid-run reset", 0, DEV, 1, 0, 1, 8'h66);
        cycle("R8 reset hold", 0, 8'h00, 0, 0, 0, 8'h00);
        cycle("R8 read after reset", 1, DEV, 1, 1, 0, 8'h00);
        idle("R8 stored cleared");
        // pseudo-random traffic near the device address
        begin
            logic [7:0] lf;
            lf = 8'h9D;
            for (int k = 0; k < 400; k++) begin
                lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                cycle("R1 R9 random traffic", 1, lf[0] ? DEV : {4'h0, lf[7:4]},
                      lf[1] | lf[2], lf[3], lf[4] | (lf[5] & lf[6]),
                      (lf[2:0] == 3'b000) ? 8'h00 : (lf ^ 8'hA5));
            end
        end
        idle("R3 final idle");
        idle("R3 final idle 2");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog all requirements: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule